// File: doc/BRIEF.md
# Integer Execution Unit with Barrel Shifter

This block is the integer execution stage of a 32-bit load/store processor. It is purely combinational: in the same cycle it takes the raw 6-bit opcode and the 6-bit function field of an instruction, together with the two register operands, the 5-bit shift-amount field and the 16-bit immediate. From these it forms a 32-bit result and an active-high overflow flag. Decoding happens inside the block, so the surrounding pipeline only has to route instruction fields and operand values to it.

The block covers four groups of operations:
- Addition and subtraction, each in a form that reports signed overflow and a form that never does.
- Bitwise logic with register or immediate operands.
- Signed and unsigned set-less-than, and load-upper-immediate.
- Left, logical-right and arithmetic-right shifts, with a constant or a variable shift amount.

Overflow is only reported as a flag and never stops execution. An encoding that the unit does not implement gives a zero result and raises an illegal-operation output. The pipeline can use that output to pass the instruction on to another unit or to raise an exception.

Top module: `risc_exu`

## Requirements
- R1: Opcode 000000 with function 100000 (add) or 100001 (add unsigned), and opcodes 001000 (addi) and 001001 (addiu), give the sum modulo 2^32. The immediate forms add the immediate sign-extended from bit 15.
- R2: Opcode 000000 with function 100010 (sub) or 100011 (sub unsigned) gives src_a minus src_b modulo 2^32.
- R3: Functions 100100 (and), 100101 (or), 100110 (xor) and 100111 (nor) combine src_a and src_b bitwise. Opcodes 001100, 001101 and 001110 perform and, or and xor with the immediate zero-extended to 32 bits.
- R4: ovf_o is 1 only in two cases. For add (function 100000) or addi (opcode 001000), it is 1 when both addends have the same sign and the sum's sign differs from it. For sub (function 100010), it is 1 when the operand signs differ and the difference's sign differs from src_a. Add unsigned, addiu, sub unsigned and every other operation hold ovf_o at 0.
- R5: Opcode 001111 (lui) gives the immediate in result bits 31:16 and zero in bits 15:0, whatever src_a holds.
- R6: Function 101010 and opcode 001010 give 1 when src_a is below the second operand as signed values, and 0 otherwise. Function 101011 and opcode 001011 do the same comparison on unsigned values. Opcode 001011 still sign-extends its immediate before comparing. Result bits 31:1 are always 0 for these operations.
- R7: Functions 000000 (shift left), 000010 (logical right) and 000011 (arithmetic right) shift src_b by shamt_i and ignore src_a. The arithmetic right shift fills with bit 31 of src_b. A shift amount of 0 returns src_b unchanged.
- R8: Functions 000100, 000110 and 000111 shift src_b left, logical right and arithmetic right by src_a[4:0]. Bits 31:5 of src_a and the shamt_i input are ignored.
- R9: An opcode outside {000000, 001000 to 001111}, or opcode 000000 with a function code outside those listed in R1 to R3 and R6 to R8, drives result_o to 0, ovf_o to 0 and illegal_o to 1. Every listed encoding drives illegal_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opc_i | input | 6 | Primary opcode field of the instruction |
| fn_i | input | 6 | Function field, used when the opcode is 000000 |
| src_a_i | input | 32 | First register operand; variable shift amount in bits 4:0 |
| src_b_i | input | 32 | Second register operand; value shifted by shift operations |
| shamt_i | input | 5 | Constant shift-amount field of the instruction |
| imm_i | input | 16 | Immediate field of the instruction |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of add, addi or sub |
| illegal_o | output | 1 | Opcode or function code is not implemented |

## Verification
The embedded assertions assume that each operand, field and opcode holds a settled value at the point where the assertion is evaluated. Because the unit is combinational, an operand that is still changing could fire a check during a transient. The bench therefore changes all inputs together on a rising clock edge and reads the outputs half a period later. It feeds every opcode and every function code, and reaches each shift and comparison through operand values that exercise sign bits, equal operands and extreme shift amounts.

// File: rtl/rexu_pkg.sv
package rexu_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'b001110;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'b001111;

  // function codes under OPC_REG
  localparam logic [FN_W-1:0] FN_SHL_C  = 6'b000000;
  localparam logic [FN_W-1:0] FN_SHRL_C = 6'b000010;
  localparam logic [FN_W-1:0] FN_SHRA_C = 6'b000011;
  localparam logic [FN_W-1:0] FN_SHL_V  = 6'b000100;
  localparam logic [FN_W-1:0] FN_SHRL_V = 6'b000110;
  localparam logic [FN_W-1:0] FN_SHRA_V = 6'b000111;
  localparam logic [FN_W-1:0] FN_ADD    = 6'b100000;
  localparam logic [FN_W-1:0] FN_ADDU   = 6'b100001;
  localparam logic [FN_W-1:0] FN_SUB    = 6'b100010;
  localparam logic [FN_W-1:0] FN_SUBU   = 6'b100011;
  localparam logic [FN_W-1:0] FN_AND    = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR     = 6'b100101;
  localparam logic [FN_W-1:0] FN_XOR    = 6'b100110;
  localparam logic [FN_W-1:0] FN_NOR    = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT    = 6'b101010;
  localparam logic [FN_W-1:0] FN_SLTU   = 6'b101011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_LUI, ALU_SHL, ALU_SHRL, ALU_SHRA, ALU_NONE
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG, OPB_SEXT, OPB_ZEXT
  } opb_sel_e;

  typedef enum logic [1:0] {
    SHM_LEFT, SHM_RLOG, SHM_RARI
  } shift_mode_e;

  typedef struct packed {
    alu_op_e  op;
    opb_sel_e b_sel;
    logic     var_shift;
    logic     ovf_en;
    logic     illegal;
  } exu_ctrl_t;

endpackage

// File: rtl/rexu_decode.sv
module rexu_decode
  import rexu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  output exu_ctrl_t        ctrl_o
);

  exu_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d           = '0;
    ctrl_d.op        = ALU_NONE;
    ctrl_d.b_sel     = OPB_REG;
    ctrl_d.var_shift = 1'b0;
    ctrl_d.ovf_en    = 1'b0;
    ctrl_d.illegal   = 1'b0;
    unique case (opc_i)
      OPC_REG: begin
        unique case (fn_i)
          FN_SHL_C:  ctrl_d.op = ALU_SHL;
          FN_SHRL_C: ctrl_d.op = ALU_SHRL;
          FN_SHRA_C: ctrl_d.op = ALU_SHRA;
          FN_SHL_V:  begin ctrl_d.op = ALU_SHL;  ctrl_d.var_shift = 1'b1; end
          FN_SHRL_V: begin ctrl_d.op = ALU_SHRL; ctrl_d.var_shift = 1'b1; end
          FN_SHRA_V: begin ctrl_d.op = ALU_SHRA; ctrl_d.var_shift = 1'b1; end
          FN_ADD:    begin ctrl_d.op = ALU_ADD;  ctrl_d.ovf_en = 1'b1; end
          FN_ADDU:   ctrl_d.op = ALU_ADD;
          FN_SUB:    begin ctrl_d.op = ALU_SUB;  ctrl_d.ovf_en = 1'b1; end
          FN_SUBU:   ctrl_d.op = ALU_SUB;
          FN_AND:    ctrl_d.op = ALU_AND;
          FN_OR:     ctrl_d.op = ALU_OR;
          FN_XOR:    ctrl_d.op = ALU_XOR;
          FN_NOR:    ctrl_d.op = ALU_NOR;
          FN_SLT:    ctrl_d.op = ALU_SLT;
          FN_SLTU:   ctrl_d.op = ALU_SLTU;
          default:   ctrl_d.illegal = 1'b1;
        endcase
      end
      OPC_ADDI:  begin ctrl_d.op = ALU_ADD;  ctrl_d.b_sel = OPB_SEXT; ctrl_d.ovf_en = 1'b1; end
      OPC_ADDIU: begin ctrl_d.op = ALU_ADD;  ctrl_d.b_sel = OPB_SEXT; end
      OPC_SLTI:  begin ctrl_d.op = ALU_SLT;  ctrl_d.b_sel = OPB_SEXT; end
      OPC_SLTIU: begin ctrl_d.op = ALU_SLTU; ctrl_d.b_sel = OPB_SEXT; end
      OPC_ANDI:  begin ctrl_d.op = ALU_AND;  ctrl_d.b_sel = OPB_ZEXT; end
      OPC_ORI:   begin ctrl_d.op = ALU_OR;   ctrl_d.b_sel = OPB_ZEXT; end
      OPC_XORI:  begin ctrl_d.op = ALU_XOR;  ctrl_d.b_sel = OPB_ZEXT; end
      OPC_LUI:   ctrl_d.op = ALU_LUI;
      default:   ctrl_d.illegal = 1'b1;
    endcase
  end

  assign ctrl_o = ctrl_d;

  // zero extension is reserved for the three logical immediates
  always_comb begin
    AST_ZEXT_LOGIC: assert (ctrl_o.b_sel != OPB_ZEXT ||
                            ctrl_o.op inside {ALU_AND, ALU_OR, ALU_XOR})
      else $error("zero-extended operand on non-logical op"); // R3
  end

endmodule

// File: rtl/rexu_addsub.sv
module rexu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(sub_i);
    sum_o  = full[W-1:0];
    // same-sign inputs to the adder with a result of the other sign
    ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    // no carry out of a + ~b + 1 means a borrow, so a < b unsigned
    lt_u_o = sub_i & ~full[W];
    lt_s_o = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : sum_o[W-1];
  end

  always_comb begin
    AST_EQUAL_NOT_LESS: assert (!(sub_i && a_i == b_i) || (!lt_s_o && !lt_u_o))
      else $error("equal operands compare as less"); // R6
    AST_SUB_EQUAL_ZERO: assert (!(sub_i && a_i == b_i) || (sum_o == '0 && !ovf_o))
      else $error("equal operands give nonzero difference"); // R2
  end

endmodule

// File: rtl/rexu_shifter.sv
module rexu_shifter
  import rexu_pkg::*;
#(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [AW-1:0] amt_i,
  input  shift_mode_e   mode_i,
  output logic [W-1:0]  res_o
);

  logic              left;
  logic              fill;
  logic [AW:0][W-1:0] stg;

  always_comb begin
    left = (mode_i == SHM_LEFT);
    fill = (mode_i == SHM_RARI) & val_i[W-1];
    // a left shift is a right shift of the bit-reversed word
    for (int i = 0; i < W; i++) begin
      stg[0][i] = left ? val_i[W-1-i] : val_i[i];
    end
  end

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      res_o[i] = left ? stg[AW][W-1-i] : stg[AW][i];
    end
  end

  always_comb begin
    AST_SHIFT_BY_ZERO: assert (amt_i != '0 || res_o == val_i)
      else $error("zero shift changed the value"); // R7
    AST_ARITH_SIGN_KEPT: assert (mode_i != SHM_RARI || res_o[W-1] == val_i[W-1])
      else $error("arithmetic shift lost the sign"); // R7
  end

endmodule

// File: rtl/risc_exu.sv
module risc_exu
  import rexu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [FN_W-1:0]    fn_i,
  input  logic [DATA_W-1:0]  src_a_i,
  input  logic [DATA_W-1:0]  src_b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [IMM_W-1:0]   imm_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               ovf_o,
  output logic               illegal_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  exu_ctrl_t          ctrl;
  logic [DATA_W-1:0]  imm_sext;
  logic [DATA_W-1:0]  imm_zext;
  logic [DATA_W-1:0]  imm_upper;
  logic [DATA_W-1:0]  opnd_b;
  logic               as_sub;
  logic [DATA_W-1:0]  as_sum;
  logic               as_ovf;
  logic               as_lt_s;
  logic               as_lt_u;
  logic [SHAMT_W-1:0] sh_amt;
  shift_mode_e        sh_mode;
  logic [DATA_W-1:0]  sh_res;

  rexu_decode u_decode (
    .opc_i  (opc_i),
    .fn_i   (fn_i),
    .ctrl_o (ctrl)
  );

  // operand formation
  always_comb begin
    imm_sext  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    imm_zext  = {{EXT_W{1'b0}}, imm_i};
    imm_upper = {imm_i, {EXT_W{1'b0}}};
    unique case (ctrl.b_sel)
      OPB_SEXT: opnd_b = imm_sext;
      OPB_ZEXT: opnd_b = imm_zext;
      default:  opnd_b = src_b_i;
    endcase
    as_sub  = ctrl.op inside {ALU_SUB, ALU_SLT, ALU_SLTU};
    sh_amt  = ctrl.var_shift ? src_a_i[SHAMT_W-1:0] : shamt_i;
    unique case (ctrl.op)
      ALU_SHRL: sh_mode = SHM_RLOG;
      ALU_SHRA: sh_mode = SHM_RARI;
      default:  sh_mode = SHM_LEFT;
    endcase
  end

  rexu_addsub #(.W(DATA_W)) u_addsub (
    .a_i    (src_a_i),
    .b_i    (opnd_b),
    .sub_i  (as_sub),
    .sum_o  (as_sum),
    .ovf_o  (as_ovf),
    .lt_s_o (as_lt_s),
    .lt_u_o (as_lt_u)
  );

  rexu_shifter #(.W(DATA_W)) u_shifter (
    .val_i  (src_b_i),
    .amt_i  (sh_amt),
    .mode_i (sh_mode),
    .res_o  (sh_res)
  );

  // result selection
  always_comb begin
    unique case (ctrl.op)
      ALU_ADD, ALU_SUB:            result_o = as_sum;
      ALU_AND:                     result_o = src_a_i & opnd_b;
      ALU_OR:                      result_o = src_a_i | opnd_b;
      ALU_XOR:                     result_o = src_a_i ^ opnd_b;
      ALU_NOR:                     result_o = ~(src_a_i | opnd_b);
      ALU_SLT:                     result_o = DATA_W'(as_lt_s);
      ALU_SLTU:                    result_o = DATA_W'(as_lt_u);
      ALU_LUI:                     result_o = imm_upper;
      ALU_SHL, ALU_SHRL, ALU_SHRA: result_o = sh_res;
      default:                     result_o = '0;
    endcase
    ovf_o     = ctrl.ovf_en & as_ovf;
    illegal_o = ctrl.illegal;
  end

  always_comb begin
    AST_ILLEGAL_QUIET: assert (!illegal_o || (result_o == '0 && !ovf_o))
      else $error("illegal op drives result or overflow"); // R9
    AST_NO_OVERFLOW: assert (!(opc_i == OPC_ADDIU ||
                               (opc_i == OPC_REG && (fn_i == FN_ADDU || fn_i == FN_SUBU)))
                             || !ovf_o)
      else $error("unsigned form raised overflow"); // R4
    AST_SLT_BOOLEAN: assert (!(opc_i inside {OPC_SLTI, OPC_SLTIU} ||
                               (opc_i == OPC_REG && fn_i inside {FN_SLT, FN_SLTU}))
                             || result_o[DATA_W-1:1] == '0)
      else $error("compare result not 0 or 1"); // R6
    AST_LUI_LOW_CLEAR: assert (opc_i != OPC_LUI || result_o[EXT_W-1:0] == '0)
      else $error("lui low half not clear"); // R5
  end

endmodule

// File: tb/risc_exu_tb_top.sv
module risc_exu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic [31:0] res;
    logic        ovf;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 6'h20, 32'h00000005, 32'h00000007, 5'd0, 16'h0000, 32'h0000000C, 1'b0, 1'b0, 8'd1}, // R1 add
    '{6'h00, 6'h20, 32'h7FFFFFFF, 32'h00000001, 5'd0, 16'h0000, 32'h80000000, 1'b1, 1'b0, 8'd4}, // R4 add ovf
    '{6'h00, 6'h21, 32'h7FFFFFFF, 32'h00000001, 5'd0, 16'h0000, 32'h80000000, 1'b0, 1'b0, 8'd4}, // R4 addu
    '{6'h00, 6'h20, 32'h80000000, 32'h80000000, 5'd0, 16'h0000, 32'h00000000, 1'b1, 1'b0, 8'd4}, // R4 neg ovf
    '{6'h08, 6'h00, 32'h7FFFFFF0, 32'h00000000, 5'd0, 16'h0010, 32'h80000000, 1'b1, 1'b0, 8'd4}, // R4 addi
    '{6'h09, 6'h00, 32'h00000010, 32'h00000000, 5'd0, 16'hFFFF, 32'h0000000F, 1'b0, 1'b0, 8'd1}, // R1 addiu sext
    '{6'h00, 6'h22, 32'h00000003, 32'h00000005, 5'd0, 16'h0000, 32'hFFFFFFFE, 1'b0, 1'b0, 8'd2}, // R2 sub
    '{6'h00, 6'h22, 32'h80000000, 32'h00000001, 5'd0, 16'h0000, 32'h7FFFFFFF, 1'b1, 1'b0, 8'd4}, // R4 sub ovf
    '{6'h00, 6'h23, 32'h80000000, 32'h00000001, 5'd0, 16'h0000, 32'h7FFFFFFF, 1'b0, 1'b0, 8'd4}, // R4 subu
    '{6'h00, 6'h22, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 16'h0000, 32'h80000000, 1'b1, 1'b0, 8'd4}, // R4 sub ovf pos
    '{6'h00, 6'h24, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0000, 32'hF000F000, 1'b0, 1'b0, 8'd3}, // R3 and
    '{6'h00, 6'h25, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0000, 32'hFFF0FFF0, 1'b0, 1'b0, 8'd3}, // R3 or
    '{6'h00, 6'h26, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0000, 32'h0FF00FF0, 1'b0, 1'b0, 8'd3}, // R3 xor
    '{6'h00, 6'h27, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0000, 32'h000F000F, 1'b0, 1'b0, 8'd3}, // R3 nor
    '{6'h0C, 6'h00, 32'hFFFFFFFF, 32'h00000000, 5'd0, 16'h8001, 32'h00008001, 1'b0, 1'b0, 8'd3}, // R3 andi
    '{6'h0D, 6'h00, 32'h12340000, 32'h00000000, 5'd0, 16'hFFFF, 32'h1234FFFF, 1'b0, 1'b0, 8'd3}, // R3 ori
    '{6'h0E, 6'h00, 32'hFFFFFFFF, 32'h00000000, 5'd0, 16'h00FF, 32'hFFFFFF00, 1'b0, 1'b0, 8'd3}, // R3 xori
    '{6'h0F, 6'h00, 32'hDEADBEEF, 32'h00000000, 5'd0, 16'hABCD, 32'hABCD0000, 1'b0, 1'b0, 8'd5}, // R5 lui
    '{6'h00, 6'h2A, 32'hFFFFFFFF, 32'h00000001, 5'd0, 16'h0000, 32'h00000001, 1'b0, 1'b0, 8'd6}, // R6 slt
    '{6'h00, 6'h2B, 32'hFFFFFFFF, 32'h00000001, 5'd0, 16'h0000, 32'h00000000, 1'b0, 1'b0, 8'd6}, // R6 sltu
    '{6'h00, 6'h2A, 32'h80000000, 32'h7FFFFFFF, 5'd0, 16'h0000, 32'h00000001, 1'b0, 1'b0, 8'd6}, // R6 slt extremes
    '{6'h0A, 6'h00, 32'hFFFFFFFE, 32'h00000000, 5'd0, 16'hFFFF, 32'h00000001, 1'b0, 1'b0, 8'd6}, // R6 slti
    '{6'h0B, 6'h00, 32'h00000005, 32'h00000000, 5'd0, 16'hFFFF, 32'h00000001, 1'b0, 1'b0, 8'd6}, // R6 sltiu sext
    '{6'h0B, 6'h00, 32'hFFFFFFFF, 32'h00000000, 5'd0, 16'hFFFF, 32'h00000000, 1'b0, 1'b0, 8'd6}, // R6 sltiu equal
    '{6'h00, 6'h00, 32'h00000000, 32'h00000001, 5'd31, 16'h0000, 32'h80000000, 1'b0, 1'b0, 8'd7}, // R7 sll 31
    '{6'h00, 6'h02, 32'h00000000, 32'h80000000, 5'd4, 16'h0000, 32'h08000000, 1'b0, 1'b0, 8'd7}, // R7 srl
    '{6'h00, 6'h03, 32'h00000000, 32'h80000000, 5'd4, 16'h0000, 32'hF8000000, 1'b0, 1'b0, 8'd7}, // R7 sra neg
    '{6'h00, 6'h03, 32'h00000000, 32'h40000000, 5'd4, 16'h0000, 32'h04000000, 1'b0, 1'b0, 8'd7}, // R7 sra pos
    '{6'h00, 6'h00, 32'h00000000, 32'h12345678, 5'd0, 16'h0000, 32'h12345678, 1'b0, 1'b0, 8'd7}, // R7 shift 0
    '{6'h00, 6'h02, 32'hFFFFFFFF, 32'h00000008, 5'd1, 16'h0000, 32'h00000004, 1'b0, 1'b0, 8'd7}, // R7 src_a ignored
    '{6'h00, 6'h04, 32'h00000024, 32'h0000000F, 5'd0, 16'h0000, 32'h000000F0, 1'b0, 1'b0, 8'd8}, // R8 sllv
    '{6'h00, 6'h06, 32'hFFFFFFE1, 32'h80000000, 5'd0, 16'h0000, 32'h40000000, 1'b0, 1'b0, 8'd8}, // R8 srlv low bits
    '{6'h00, 6'h07, 32'h0000001F, 32'h80000000, 5'd0, 16'h0000, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd8}, // R8 srav
    '{6'h00, 6'h04, 32'h00000001, 32'h00000001, 5'd31, 16'h0000, 32'h00000002, 1'b0, 1'b0, 8'd8}, // R8 shamt ignored
    '{6'h3F, 6'h20, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 16'hFFFF, 32'h00000000, 1'b0, 1'b1, 8'd9}, // R9 bad opcode
    '{6'h00, 6'h01, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 16'hFFFF, 32'h00000000, 1'b0, 1'b1, 8'd9}, // R9 bad funct
    '{6'h04, 6'h00, 32'h7FFFFFFF, 32'h00000001, 5'd0, 16'h0001, 32'h00000000, 1'b0, 1'b1, 8'd9}  // R9 branch opcode
  };

  logic        clk;
  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [4:0]  shamt;
  logic [15:0] imm;
  logic [31:0] result;
  logic        ovf;
  logic        illegal;

  int n_checks;
  int n_fail;
  int cycles;
  bit done;

  risc_exu dut_i (
    .opc_i     (opc),
    .fn_i      (fn),
    .src_a_i   (src_a),
    .src_b_i   (src_b),
    .shamt_i   (shamt),
    .imm_i     (imm),
    .result_o  (result),
    .ovf_o     (ovf),
    .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit fn_legal(input logic [5:0] f);
    return f inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07,
                     6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
                     6'h26, 6'h27, 6'h2A, 6'h2B};
  endfunction

  task automatic apply(input logic [5:0] o, input logic [5:0] f, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s, input logic [15:0] i);
    @(posedge clk);
    opc = o; fn = f; src_a = a; src_b = b; shamt = s; imm = i;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic eo, input logic ei);
    n_checks++;
    if (result !== er || ovf !== eo || illegal !== ei) begin
      n_fail++;
      $display("FAIL %s: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
               tag, result, ovf, illegal, er, eo, ei);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; cycles = 0; done = 1'b0;
    opc = '0; fn = '0; src_a = '0; src_b = '0; shamt = '0; imm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state: all-zero instruction is a zero shift of zero (R7)
    check("R7 idle zero inputs", 32'h0, 1'b0, 1'b0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].opc, VECS[v].fn, VECS[v].a, VECS[v].b, VECS[v].sh, VECS[v].imm);
      check($sformatf("R%0d vector %0d", VECS[v].req, v), VECS[v].res, VECS[v].ovf, VECS[v].ill);
    end

    // R9: every function code under opcode 000000
    for (int f = 0; f < 64; f++) begin
      logic [5:0] fv;
      fv = 6'(f);
      apply(6'h00, fv, 32'h0, 32'h0, 5'd0, 16'h0);
      n_checks++;
      if (illegal !== !fn_legal(fv) || (illegal && (result !== 32'h0 || ovf !== 1'b0))) begin
        n_fail++;
        $display("FAIL R9 funct %h: got ill=%b res=%h, expected ill=%b",
                 fv, illegal, result, !fn_legal(fv));
      end
    end

    // R9: every nonzero opcode
    for (int o = 1; o < 64; o++) begin
      logic [5:0] ov;
      logic       exp_ill;
      ov = 6'(o);
      exp_ill = !(ov >= 6'h08 && ov <= 6'h0F);
      apply(ov, 6'h20, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 16'h7FFF);
      n_checks++;
      if (illegal !== exp_ill || (exp_ill && (result !== 32'h0 || ovf !== 1'b0))) begin
        n_fail++;
        $display("FAIL R9 opcode %h: got ill=%b res=%h ovf=%b, expected ill=%b",
                 ov, illegal, result, ovf, exp_ill);
      end
    end

    // R8: every variable left-shift amount, upper src_a bits set
    for (int s = 0; s < 32; s++) begin
      apply(6'h00, 6'h04, 32'hFFFFFFE0 | 32'(s), 32'h00000001, 5'(31 - s), 16'h0);
      check($sformatf("R8 sllv by %0d", s), 32'h1 << s, 1'b0, 1'b0);
    end

    // R5: lui ignores src_a
    apply(6'h0F, 6'h3F, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd7, 16'h0001);
    check("R5 lui src_a ignored", 32'h00010000, 1'b0, 1'b0);

    // R1: addi with negative immediate producing wraparound
    apply(6'h08, 6'h00, 32'h00000000, 32'h0, 5'd0, 16'h8000);
    check("R1 addi most negative imm", 32'hFFFF8000, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule